// File: doc/BRIEF.md
# Bus-Mapped Seconds Counter with Alarm

This block is a memory-mapped real-time clock built around a 32-bit seconds counter. A prescaler divides the system clock by `CLK_HZ` to make a one-cycle tick once per second. On each tick the counter advances by one and wraps modulo 2^32. Software can read the count and load a new value into it. It can also program an alarm value that is compared against the count as it wraps.

When the count reaches the alarm value, a raw status bit is set. The raw bit is ANDed with a mask bit to drive a single level interrupt. Software clears the raw bit by writing any value to the clear register.

Access is through a simple APB-style slave that decodes a 4 KB window. The block completes every access with no wait states. The top eight words of the window hold fixed identification bytes. An access to an offset that is not decoded reads as zero and raises the error response.

Top module: `secs_rtc`

## Requirements
- R1: After reset, the count (offset 0x00), alarm (0x04), mask (0x10) and raw status (0x14) read 0, and `irq` is 0.
- R2: The count advances by exactly one on every `CLK_HZ`-th clock. A load restarts the prescaler phase, so the first increment after a load comes `CLK_HZ` clocks after the load's access edge.
- R3: A write to offset 0x08 sets the count to the written data. Counting continues from that value. A read of 0x08 returns the last value written there.
- R4: The count wraps from 0xFFFFFFFF to 0x00000000. An alarm value that is numerically below the count still fires after the wrap.
- R5: The raw status bit is set on the tick whose new count equals the alarm value. It is not set before that tick.
- R6: `irq` equals raw status AND mask bit 0. A read of offset 0x18 returns that same value. With the mask at 0, `irq` stays 0 while the raw bit is 1.
- R7: Any write to offset 0x1C clears the raw bit, whatever the data. If the clear happens on the same clock as a setting tick, the set wins.
- R8: Offset 0x0C always reads 1, and writes to it have no effect.
- R9: Writes to 0x00, 0x14 and 0x18 are ignored. A read of 0x1C returns 0. Neither kind of access raises the error response.
- R10: Any access to an offset outside 0x00–0x1C and 0xFE0–0xFFC returns `prdata` 0 with `pslverr` 1.
- R11: A read of word offsets 0xFE0 through 0xFFC returns, in the low byte, the bytes 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. The byte index is (offset − 0xFE0) >> 2, and the upper bits are 0.
- R12: The mask and status registers hold only bit 0. Writing 0xFFFFFFFF to the mask reads back as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error response for an undecoded offset |
| irq | output | 1 | Masked alarm interrupt |

## Verification
The bench builds the block with `CLK_HZ` = 4, so one second lasts four clocks. At that rate every tick lands on a clock edge the bench can name exactly. That makes it possible to sample the count one clock before and one clock after an increment. It also lets the bench place an interrupt clear on the very edge where the alarm sets, and carry the count through a wrap from 0xFFFFFFFF in a few cycles.

// File: rtl/secs_rtc.sv
module secs_rtc #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        pslverr,
  output logic        irq
);
  localparam int unsigned DIV_W = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(CLK_HZ - 1);

  localparam logic [9:0] W_CNT  = 10'h000;
  localparam logic [9:0] W_ALM  = 10'h001;
  localparam logic [9:0] W_LOAD = 10'h002;
  localparam logic [9:0] W_CTL  = 10'h003;
  localparam logic [9:0] W_MASK = 10'h004;
  localparam logic [9:0] W_RAW  = 10'h005;
  localparam logic [9:0] W_MSK  = 10'h006;
  localparam logic [9:0] W_CLR  = 10'h007;
  localparam logic [9:0] W_ID0  = 10'h3F8;

  logic [DIV_W-1:0] div_q;
  logic [31:0]      cnt_q, match_q, ld_q, cnt_nxt;
  logic             im_q, ris_q;
  logic             access, wr, tick, load_wr, clr_wr, set_raw, known;
  logic [9:0]       word;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  assign word    = paddr[11:2];
  assign access  = psel && penable;
  assign wr      = access && pwrite;
  assign tick    = (div_q == DIV_TOP);
  assign load_wr = wr && (word == W_LOAD);
  assign clr_wr  = wr && (word == W_CLR);
  assign cnt_nxt = cnt_q + 32'd1;
  assign set_raw = tick && !load_wr && (cnt_nxt == match_q);
  assign known   = (word <= W_CLR) || (word >= W_ID0);
  assign pslverr = access && !known;
  assign irq     = ris_q && im_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load_wr) begin
      div_q <= '0;
      cnt_q <= pwdata;
    end else if (tick) begin
      div_q <= '0;
      cnt_q <= cnt_nxt;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_q <= '0;
      ld_q    <= '0;
      im_q    <= 1'b0;
    end else if (wr) begin
      if (word == W_ALM)  match_q <= pwdata;
      if (word == W_LOAD) ld_q    <= pwdata;
      if (word == W_MASK) im_q    <= pwdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ris_q <= 1'b0;
    else if (set_raw) ris_q <= 1'b1;
    else if (clr_wr)  ris_q <= 1'b0;
  end

  always_comb begin
    prdata = '0;
    if (word >= W_ID0) begin
      prdata = {24'd0, id_byte(word[2:0])};
    end else begin
      case (word)
        W_CNT:   prdata = cnt_q;
        W_ALM:   prdata = match_q;
        W_LOAD:  prdata = ld_q;
        W_CTL:   prdata = 32'd1;
        W_MASK:  prdata = {31'd0, im_q};
        W_RAW:   prdata = {31'd0, ris_q};
        W_MSK:   prdata = {31'd0, irq};
        default: prdata = '0;
      endcase
    end
  end
endmodule

module secs_rtc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        access,
  input logic        pwrite,
  input logic [9:0]  word,
  input logic        tick,
  input logic        load_wr,
  input logic        clr_wr,
  input logic        set_raw,
  input logic [31:0] cnt_q,
  input logic [31:0] match_q,
  input logic        ris_q,
  input logic [31:0] prdata,
  input logic        pslverr
);
  // R2
  cnt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(tick || load_wr));
  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && !$past(load_wr)) |-> (cnt_q == $past(cnt_q) + 32'd1));
  // R5
  raw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ris_q) |-> ($past(tick) && cnt_q == $past(match_q)));
  // R7
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_wr && !set_raw) |-> !ris_q);
  // R10
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (prdata == 32'd0));
  // R8
  ctl_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !pwrite && word == 10'h003) |-> (prdata == 32'd1));
endmodule

bind secs_rtc secs_rtc_chk u_chk (.*);

// File: tb/secs_rtc_tb.sv
module secs_rtc_tb;
  localparam int unsigned HZ = 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pslverr, irq;

  int checks = 0, errors = 0;
  logic [31:0] rd;
  logic        er;
  bit          done = 1'b0;

  secs_rtc #(.CLK_HZ(HZ)) u_dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    #1 er = pslverr;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1;
    #1 rd = prdata; er = pslverr;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq", {31'd0, irq}, 32'd0);
    apb_rd(12'h000); chk("R1 count", rd, 32'd0);
    apb_rd(12'h004); chk("R1 alarm", rd, 32'd0);
    apb_rd(12'h010); chk("R1 mask", rd, 32'd0);
    apb_rd(12'h014); chk("R1 raw", rd, 32'd0);
  endtask

  task automatic t_load_prescale();
    apb_wr(12'h008, 32'h1234_5678);
    apb_rd(12'h000); chk("R3 load count", rd, 32'h1234_5678);
    apb_rd(12'h008); chk("R3 load readback", rd, 32'h1234_5678);
    apb_wr(12'h008, 32'h0000_1000);
    idle(2); apb_rd(12'h000); chk("R2 before tick", rd, 32'h0000_1000);
    apb_wr(12'h008, 32'h0000_2000);
    idle(3); apb_rd(12'h000); chk("R2 after tick", rd, 32'h0000_2001);
  endtask

  task automatic t_ignored();
    apb_wr(12'h008, 32'h0000_0500);
    apb_wr(12'h000, 32'h0000_0055); chk("R9 data write no err", {31'd0, er}, 32'd0);
    apb_rd(12'h000); chk("R9 data write ignored", rd, 32'h0000_0500);
    apb_wr(12'h014, 32'h1); apb_rd(12'h014); chk("R9 raw write ignored", rd, 32'd0);
    apb_wr(12'h018, 32'h1); apb_rd(12'h018); chk("R9 masked write ignored", rd, 32'd0);
    apb_rd(12'h01C); chk("R9 clear reads 0", rd, 32'd0);
    chk("R9 clear read no err", {31'd0, er}, 32'd0);
    apb_wr(12'h00C, 32'h0); apb_rd(12'h00C); chk("R8 control", rd, 32'd1);
  endtask

  task automatic t_mask_bits();
    apb_wr(12'h010, 32'hFFFF_FFFF); apb_rd(12'h010); chk("R12 mask bit0", rd, 32'd1);
  endtask

  task automatic t_alarm();
    apb_wr(12'h004, 32'h0000_0100);
    apb_rd(12'h004); chk("R5 alarm readback", rd, 32'h0000_0100);
    apb_wr(12'h01C, 32'h0);
    apb_wr(12'h008, 32'h0000_00FE);
    idle(7); #1 chk("R5 not yet", {31'd0, irq}, 32'd0);
    @(negedge clk); #1 chk("R5 fires", {31'd0, irq}, 32'd1);
    apb_rd(12'h018); chk("R6 masked status", rd, 32'd1);
    apb_wr(12'h01C, 32'hDEAD_0000); apb_rd(12'h014); chk("R7 clear any data", rd, 32'd0);
    chk("R7 irq low", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_masked_off();
    apb_wr(12'h010, 32'h0);
    apb_wr(12'h004, 32'h0000_0302);
    apb_wr(12'h008, 32'h0000_0300);
    idle(9);
    chk("R6 irq masked", {31'd0, irq}, 32'd0);
    apb_rd(12'h014); chk("R6 raw set", rd, 32'd1);
    apb_rd(12'h018); chk("R6 masked reads 0", rd, 32'd0);
    apb_wr(12'h01C, 32'h0);
  endtask

  task automatic t_set_wins();
    apb_wr(12'h010, 32'h1);
    apb_wr(12'h004, 32'h0000_0402);
    apb_wr(12'h008, 32'h0000_0400);
    idle(6);
    apb_wr(12'h01C, 32'h0);
    apb_rd(12'h014); chk("R7 set wins", rd, 32'd1);
    apb_wr(12'h01C, 32'h0);
    apb_rd(12'h014); chk("R7 later clear", rd, 32'd0);
  endtask

  task automatic t_wrap();
    apb_wr(12'h004, 32'h0000_0001);
    apb_wr(12'h008, 32'hFFFF_FFFF);
    idle(3); apb_rd(12'h000); chk("R4 wrap to 0", rd, 32'd0);
    idle(3); #1 chk("R4 alarm after wrap", {31'd0, irq}, 32'd1);
    apb_wr(12'h01C, 32'h0);
  endtask

  task automatic t_undef_id();
    apb_rd(12'h020); chk("R10 undef data", rd, 32'd0); chk("R10 undef err", {31'd0, er}, 32'd1);
    apb_rd(12'hFDC); chk("R10 below id", rd, 32'd0); chk("R10 below id err", {31'd0, er}, 32'd1);
    apb_wr(12'h800, 32'h1); chk("R10 undef write err", {31'd0, er}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h31; 1: e = 8'h10; 2: e = 8'h14; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      apb_rd(12'hFE0 + 12'(i * 4));
      chk("R11 id byte", rd, {24'd0, e});
      chk("R11 id no err", {31'd0, er}, 32'd0);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    t_reset();
    t_load_prescale();
    t_ignored();
    t_mask_bits();
    t_alarm();
    t_masked_off();
    t_set_wins();
    t_wrap();
    t_undef_id();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule